// File: doc/BRIEF.md
# Saturating 8-bit PWM Generator

This block drives one pulse-width-modulated output whose period is 250 counts rather than a power of two. A period counter advances once per `tick` while the channel runs and returns to zero after count 249. The output is high while the count is below the active duty value. An 8-bit duty code sets the number of high counts in each period. Because the period is shorter than the code range, codes from 250 to 255 all keep the output high for the whole period.

Software writes a duty code into a buffer register with `duty_wr`. The compare register that drives the output takes the buffer value only at a period boundary, so a change never cuts a period short or stretches it. The `enable` input moves a two-state control machine between its two states:

- **ST_HALT**: the counter is held at zero, the output is low, and the compare register copies the buffer on every clock. The transition HALT→RUN happens on the first clock edge with `enable` high.
- **ST_RUN**: the counter advances on each `tick`. The transition RUN→HALT happens on the first clock edge with `enable` low.

Top module: `sat_pwm_gen`

## Requirements
- R1: After reset the output is low, the control machine is in ST_HALT, and both the buffer and the compare register hold duty code 0x00.
- R2: In ST_RUN the counter steps by one on each clock with `tick` high and goes from 249 back to 0. One period is therefore 250 ticks, and the first count after entering ST_RUN is 0.
- R3: While running, the output is high exactly when count < active duty. A code d in 1..249 gives d high counts per period, starting at count 0. Code 0x00 keeps the output always low, and code 0x7D gives 125 high counts out of 250.
- R4: Codes 0xFA through 0xFF (250..255) keep the output high for all 250 counts of every period.
- R5: A code written with `duty_wr` while running is stored in the buffer only. It reaches the compare register on the wrap from 249 to 0, so the period in progress keeps the old duty.
- R6: If `duty_wr` and the wrap from 249 to 0 fall on the same clock edge, the wrap loads the buffer value from before the write. The new code takes effect at the following wrap.
- R7: While `enable` is low, the output is low within the same cycle. The machine enters ST_HALT at the next edge, the counter is forced to 0, and the compare register tracks the buffer. Re-enabling starts a fresh period at count 0 with the buffered duty.
- R8: With `tick` low, the counter and the output hold their values for any number of clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Channel run control |
| tick | input | 1 | Count advance strobe (one clock wide per count) |
| duty_wr | input | 1 | Write strobe for the duty buffer |
| duty_in | input | 8 | Duty code to be written |
| pwm_out | output | 1 | PWM output |

## Verification
The bench measures whole periods across the code range, including 0x00, 1, 0x7D, 249, 250 and the saturated codes 251 and 255. A comparator that is off by one, or that wraps the code modulo the period, shows up as a wrong high count. A write in the middle of a period, and a write on the very wrap edge, are timed from the output. A design without double buffering, or one that bypasses the buffer at the wrap, would change duty one period early. Disabling in mid-period and then re-enabling catches a counter that resumes rather than restarts. A long stall of `tick` catches a counter that runs without its strobe.

// File: rtl/sat_pwm_pkg.sv
package sat_pwm_pkg;
    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } pwm_state_e;
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
    parameter int PERIOD = 250,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] count_d;

    assign wrap = run && tick && (count == LAST);

    always_comb begin
        count_d = count;
        if (!run) begin
            count_d = '0;
        end else if (tick) begin
            count_d = (count == LAST) ? '0 : count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count_d;
    end

    // R2: count stays within the period
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);
    // R2: last count returns to zero on a tick
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && count == LAST) |=> count == '0);
    // R8: no tick, no movement
    p_hold_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(count));
    // R7: halted counter sits at zero
    p_halt_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> count == '0);
endmodule

// File: rtl/pwm_duty_buffer.sv
module pwm_duty_buffer #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DUTY_W-1:0] din,
    input  logic              load,
    output logic [DUTY_W-1:0] active
);
    logic [DUTY_W-1:0] pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pending <= '0;
        else if (wr) pending <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    active <= '0;
        else if (load) active <= pending;
    end

    // R5: compare value moves only on a load
    p_hold_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active));
    // R6: a load takes the value buffered before a same-edge write
    p_old_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && wr) |=> active == $past(pending));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CNT_W  = 8,
    parameter int DUTY_W = 8
) (
    input  logic [CNT_W-1:0]  count,
    input  logic [DUTY_W-1:0] active,
    output logic              above
);
    always_comb begin
        above = int'(count) < int'(active);
    end
endmodule

// File: rtl/sat_pwm_gen.sv
module sat_pwm_gen
    import sat_pwm_pkg::*;
#(
    parameter int PERIOD = 250,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_in,
    output logic              pwm_out
);
    localparam int CNT_W = $clog2(PERIOD);

    pwm_state_e        state_q, state_d;
    logic [CNT_W-1:0]  count;
    logic              wrap;
    logic              load;
    logic [DUTY_W-1:0] active;
    logic              above;
    logic              running;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (enable)  state_d = ST_RUN;
            ST_RUN:  if (!enable) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    assign running = (state_q == ST_RUN);
    assign load    = !running || wrap;

    pwm_period_counter #(.PERIOD(PERIOD), .CNT_W(CNT_W)) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .tick  (tick),
        .count (count),
        .wrap  (wrap)
    );

    pwm_duty_buffer #(.DUTY_W(DUTY_W)) i_buffer (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (duty_wr),
        .din    (duty_in),
        .load   (load),
        .active (active)
    );

    pwm_compare #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) i_compare (
        .count  (count),
        .active (active),
        .above  (above)
    );

    always_comb begin
        pwm_out = 1'b0;
        unique case (state_q)
            ST_HALT: pwm_out = 1'b0;
            ST_RUN:  pwm_out = enable && above;
            default: pwm_out = 1'b0;
        endcase
    end

    // R3: the output can only rise at the start of a period
    p_rise_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> count == '0);
    // R4: saturated codes keep the output high through the next cycle
    p_sat_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && enable && int'(active) >= PERIOD && !wrap) |=> (pwm_out || !enable));
    // R7: halted state never drives the output
    p_halt_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HALT |-> !pwm_out);
endmodule

// File: tb/test_sat_pwm_gen.sv
`timescale 1ns/1ps
module test_sat_pwm_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       tick = 1'b0;
    logic       duty_wr = 1'b0;
    logic [7:0] duty_in = 8'h00;
    logic       pwm_out;

    int n_cmp = 0;
    int n_bad = 0;

    localparam int PER = 250;
    localparam int NV  = 9;
    // {duty code, expected high counts per period}
    localparam logic [15:0] VEC [NV] = '{
        {8'h00, 8'd0}, {8'h01, 8'd1}, {8'h40, 8'd64}, {8'h7D, 8'd125},
        {8'hF9, 8'd249}, {8'hFA, 8'd250}, {8'hFB, 8'd250}, {8'hFF, 8'd250},
        {8'h20, 8'd32}
    };

    always #2.5 clk = ~clk;

    sat_pwm_gen i_sat_pwm_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tick    (tick),
        .duty_wr (duty_wr),
        .duty_in (duty_in),
        .pwm_out (pwm_out)
    );

    task automatic check(input string req, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Samples PER outputs at falling edges; writes wval after sample wr_at.
    task automatic sample_period(output int hi, input int wr_at, input logic [7:0] wval);
        hi = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
            duty_wr = (i == wr_at);
            duty_in = wval;
        end
    endtask

    // Halt, load a code, restart; next falling edge shows count 0.
    task automatic restart_with(input logic [7:0] d);
        @(negedge clk);
        enable = 1'b0; tick = 1'b1; duty_wr = 1'b1; duty_in = d;
        @(negedge clk);
        duty_wr = 1'b0;
        @(negedge clk);
        enable = 1'b1;
    endtask

    initial begin
        int hi;
        int b;
        repeat (3) @(negedge clk);
        check("R1 output after reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 output idle", int'(pwm_out), 0);
        // R1: running without any write uses code 0x00
        enable = 1'b1; tick = 1'b1;
        sample_period(hi, -1, 8'h00);
        check("R1 reset duty is zero", hi, 0);

        // R3 R4 table walk
        for (int v = 0; v < NV; v++) begin
            restart_with(VEC[v][15:8]);
            sample_period(hi, -1, 8'h00);
            check("R3/R4 highs per period", hi, int'(VEC[v][7:0]));
            @(negedge clk);
            check("R2 period restarts at count 0", int'(pwm_out), (VEC[v][7:0] != 0) ? 1 : 0);
        end

        // R5: write in mid-period waits for the wrap
        restart_with(8'h00);
        sample_period(hi, 10, 8'hFA);
        check("R5 current period keeps old duty", hi, 0);
        sample_period(hi, -1, 8'h00);
        check("R5 new duty after wrap", hi, 250);

        // R6: write on the wrap edge
        restart_with(8'h10);
        sample_period(hi, 249, 8'h80);
        check("R6 period before write", hi, 16);
        sample_period(hi, -1, 8'h00);
        check("R6 wrap takes old buffer", hi, 16);
        sample_period(hi, -1, 8'h00);
        check("R6 new code one period later", hi, 128);

        // R7: disable in mid-period, then restart
        restart_with(8'h7D);
        for (int i = 0; i < 50; i++) @(negedge clk);
        check("R7 high before disable", int'(pwm_out), 1);
        enable = 1'b0;
        #0.5;
        check("R7 low in same cycle", int'(pwm_out), 0);
        b = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_out) b++;
        end
        check("R7 low while halted", b, 0);
        enable = 1'b1;
        sample_period(hi, -1, 8'h00);
        check("R7 fresh period after re-enable", hi, 125);

        // R8: tick stall holds the count
        restart_with(8'h7D);
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        tick = 1'b0;
        b = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!pwm_out) b++;
        end
        check("R8 output held during stall", b, 0);
        tick = 1'b1;
        for (int i = 0; i < 240; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        check("R8 period resumes with no lost count", hi, 125);
        @(negedge clk);
        check("R8 wrap after resumed period", int'(pwm_out), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule